// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges every reset request of a small system into a single system reset and owns the shared, bidirectional reset pin. The inputs are a power-on request, a low-voltage indication, a watchdog timeout, an illegal-opcode trap, an illegal-address trap, a reset forced by the debugger and the external pin itself. Once any request is seen, the block pulls the pin low for a fixed number of bus cycles. It then lets the pin go back to its pullup, waits a second fixed interval and samples the pin. A pin that is still low at that moment shows that something outside the chip is holding reset.

The cause of the last reset is kept in an 8-bit read-only status word. A new reset wipes the old causes. Power-on wins over every other cause. The low-voltage input and the pin are asynchronous and pass through two-flop synchronizers. The power-on input asserts the system reset and the pin drive combinationally, so they do not wait for a clock edge. It also acts as the synchronous active-high reset of every flop.

Top module: `rstseq_top`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` and `pin_drive_o` are high in the same cycle. The status reads 0x80 (bit 7 set), or 0x82 if `lvd_i` is also high (bit 1 set).
- R2: A reset entered from idle drives `pin_drive_o` high for exactly DRIVE_CYC (34) consecutive bus cycles. This holds for any request and also after power-on is released.
- R3: After the pin is released, `sys_rst_o` stays high for exactly SAMPLE_CYC (38) further cycles and then falls.
- R4: Status bit positions are: watchdog bit 5, illegal opcode bit 4, illegal address bit 3, low voltage bit 1. A new reset clears every older bit and sets the bits of the causes present at entry.
- R5: A cause that arrives while a non-power-on reset sequence is running is ORed into the status.
- R6: The debugger-forced request resets the system but sets no status bit. Bits 2 and 0 always read 0.
- R7: The pin is sampled in the last cycle of the SAMPLE_CYC window. If it is low then, bit 6 is set. If it has been released by then, bit 6 stays clear.
- R8: The synchronous requests (watchdog, opcode, address, debug) raise `sys_rst_o` one cycle after they are presented. The low-voltage input and the pin go through two synchronizer stages and raise it three cycles after they are presented.
- R9: Power-on during a running sequence restarts it, and the status holds only the power-on image. Other requests present at that time are ignored.
- R10: With no request, `sys_rst_o` and `pin_drive_o` stay low and the status keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_i | input | 1 | Power-on request, active high; also the synchronous reset of all state |
| lvd_i | input | 1 | Low-voltage indication, asynchronous |
| wdog_i | input | 1 | Watchdog timeout request, synchronous |
| badop_i | input | 1 | Illegal-opcode request, synchronous |
| badaddr_i | input | 1 | Illegal-address request, synchronous |
| dbg_i | input | 1 | Debugger-forced reset request, synchronous |
| pin_i | input | 1 | Sensed level of the reset pin, asynchronous, low means reset |
| pin_drive_o | output | 1 | Open-drain enable; high pulls the reset pin low |
| sys_rst_o | output | 1 | System reset to the rest of the chip, active high |
| status_o | output | 8 | Read-only reset cause word |

## Verification
The bench sweeps each synchronous cause and the low-voltage input one at a time from idle. Single-cause runs separate the bit mapping and the entry delay of synchronized and unsynchronized paths, and they show that each new reset clears the previous cause. The pin is tried in three ways: held until just before the sample point, released well before it, and as a start of reset on its own. These runs separate a true external pin reset from a short glitch. Further runs add a second cause mid-sequence, apply power-on on top of a running watchdog reset, and apply power-on with and without low voltage. These show OR-accumulation, power-on precedence and exact drive and wait lengths.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int ST_W = 8;

    localparam int B_POR  = 7;
    localparam int B_PIN  = 6;
    localparam int B_WDOG = 5;
    localparam int B_OPC  = 4;
    localparam int B_ADR  = 3;
    localparam int B_LVD  = 1;

    localparam logic [ST_W-1:0] PIN_MASK    = ST_W'(1) << B_PIN;
    localparam logic [ST_W-1:0] UNUSED_MASK = 8'b0000_0101;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DRIVE = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

    typedef struct packed {
        logic lvd;
        logic wdog;
        logic opc;
        logic adr;
        logic dbg;
        logic pin_low;
    } req_t;

    function automatic logic any_req(req_t r);
        return r.lvd | r.wdog | r.opc | r.adr | r.dbg | r.pin_low;
    endfunction

    // Bits recorded for a request vector; pin and debug leave no trace here.
    function automatic logic [ST_W-1:0] cause_bits(req_t r);
        logic [ST_W-1:0] v;
        v         = '0;
        v[B_WDOG] = r.wdog;
        v[B_OPC]  = r.opc;
        v[B_ADR]  = r.adr;
        v[B_LVD]  = r.lvd;
        return v;
    endfunction

    function automatic logic [ST_W-1:0] por_image(logic lvd);
        logic [ST_W-1:0] v;
        v        = '0;
        v[B_POR] = 1'b1;
        v[B_LVD] = lvd;
        return v;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic por,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (por) sh <= {STAGES{RST_VAL}};
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
    import rstseq_pkg::*;
#(
    parameter int DRIVE_CYC  = 34,
    parameter int SAMPLE_CYC = 38
) (
    input  logic   clk,
    input  logic   por,
    input  logic   req,
    output phase_e phase,
    output logic   start,
    output logic   sample_now,
    output logic   por_run,
    output logic   por_pend
);
    localparam int MAXC  = (DRIVE_CYC > SAMPLE_CYC) ? DRIVE_CYC : SAMPLE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(DRIVE_CYC - 1);
    localparam logic [CNT_W-1:0] SMP_LAST = CNT_W'(SAMPLE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        start      = !por && (phase == PH_IDLE) && (req || por_pend);
        sample_now = !por && (phase == PH_WAIT) && (cnt == SMP_LAST);
    end

    always_ff @(posedge clk) begin
        if (por) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            por_pend <= 1'b1;
            por_run  <= 1'b1;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase    <= PH_DRIVE;
                    cnt      <= '0;
                    por_pend <= 1'b0;
                end
                PH_DRIVE: if (cnt == DRV_LAST) begin
                    phase <= PH_WAIT;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_WAIT: if (cnt == SMP_LAST) begin
                    phase   <= PH_IDLE;
                    cnt     <= '0;
                    por_run <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
    import rstseq_pkg::*;
(
    input  logic            clk,
    input  logic            por,
    input  logic            lvd_raw,
    input  logic            start,
    input  logic            seq_on,
    input  logic            por_run,
    input  logic            sample_now,
    input  logic            pin_s,
    input  logic [ST_W-1:0] cause_now,
    output logic [ST_W-1:0] status
);
    logic [ST_W-1:0] pin_add;

    assign pin_add = (sample_now && !pin_s) ? PIN_MASK : '0;

    always_ff @(posedge clk) begin
        if (por) begin
            status <= por_image(lvd_raw);
        end else if (!por_run) begin
            if (start)       status <= cause_now;
            else if (seq_on) status <= status | cause_now | pin_add;
        end
    end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int DRIVE_CYC  = 34,
    parameter int SAMPLE_CYC = 38,
    parameter int SYNC_STG   = 2
) (
    input  logic            clk,
    input  logic            por_i,
    input  logic            lvd_i,
    input  logic            wdog_i,
    input  logic            badop_i,
    input  logic            badaddr_i,
    input  logic            dbg_i,
    input  logic            pin_i,
    output logic            pin_drive_o,
    output logic            sys_rst_o,
    output logic [ST_W-1:0] status_o
);
    logic   pin_s, lvd_s;
    req_t   rq;
    phase_e phase;
    logic   start, sample_now, por_run, por_pend;

    rstseq_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .por(por_i), .d(pin_i), .q(pin_s)
    );

    rstseq_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_lvd_sync (
        .clk(clk), .por(por_i), .d(lvd_i), .q(lvd_s)
    );

    always_comb begin
        rq.lvd     = lvd_s;
        rq.wdog    = wdog_i;
        rq.opc     = badop_i;
        rq.adr     = badaddr_i;
        rq.dbg     = dbg_i;
        rq.pin_low = !pin_s;
    end

    rstseq_timer #(.DRIVE_CYC(DRIVE_CYC), .SAMPLE_CYC(SAMPLE_CYC)) u_timer (
        .clk(clk), .por(por_i), .req(any_req(rq)), .phase(phase),
        .start(start), .sample_now(sample_now), .por_run(por_run),
        .por_pend(por_pend)
    );

    rstseq_cause u_cause (
        .clk(clk), .por(por_i), .lvd_raw(lvd_i), .start(start),
        .seq_on(phase != PH_IDLE), .por_run(por_run),
        .sample_now(sample_now), .pin_s(pin_s),
        .cause_now(cause_bits(rq)), .status(status_o)
    );

    assign pin_drive_o = por_i | por_pend | (phase == PH_DRIVE);
    assign sys_rst_o   = por_i | por_pend | (phase != PH_IDLE);
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk
    import rstseq_pkg::*;
#(
    parameter int DRIVE_CYC  = 34,
    parameter int SAMPLE_CYC = 38
) (
    input logic            clk,
    input logic            por_i,
    input logic            pin_drive_o,
    input logic            sys_rst_o,
    input logic [ST_W-1:0] status_o
);
    int drv_run;
    int wait_run;

    always_ff @(posedge clk) begin
        if (por_i) begin
            drv_run  <= 0;
            wait_run <= 0;
        end else begin
            drv_run  <= pin_drive_o ? drv_run + 1 : 0;
            wait_run <= (sys_rst_o && !pin_drive_o) ? wait_run + 1 : 0;
        end
    end

    // R1
    por_image_chk: assert property (@(posedge clk) disable iff (por_i)
        $past(por_i) |-> status_o[B_POR]);

    // R2
    drive_len_chk: assert property (@(posedge clk) disable iff (por_i)
        drv_run <= DRIVE_CYC + 1);

    // R2
    drive_in_reset_chk: assert property (@(posedge clk) disable iff (por_i)
        pin_drive_o |-> sys_rst_o);

    // R3
    wait_follows_chk: assert property (@(posedge clk) disable iff (por_i)
        $fell(pin_drive_o) |-> sys_rst_o);

    // R3
    wait_len_chk: assert property (@(posedge clk) disable iff (por_i)
        wait_run <= SAMPLE_CYC);

    // R6
    unused_bits_chk: assert property (@(posedge clk) disable iff (por_i)
        (status_o & UNUSED_MASK) == '0);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        (!sys_rst_o && !$past(sys_rst_o)) |-> $stable(status_o));
endmodule

bind rstseq_top rstseq_chk #(.DRIVE_CYC(DRIVE_CYC), .SAMPLE_CYC(SAMPLE_CYC)) u_chk (
    .clk(clk), .por_i(por_i), .pin_drive_o(pin_drive_o),
    .sys_rst_o(sys_rst_o), .status_o(status_o)
);

// File: tb/rstseq_top_tb_top.sv
module rstseq_top_tb_top;
    localparam int DRV = 34;
    localparam int SMP = 38;

    logic clk = 1'b0;
    logic por = 1'b1, lvd = 1'b0, wdog = 1'b0, badop = 1'b0;
    logic badaddr = 1'b0, dbg = 1'b0, ext_low = 1'b0;
    logic pin_drive, sys_rst, pin_w;
    logic [7:0] status;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign pin_w = !(ext_low | pin_drive);

    rstseq_top #(.DRIVE_CYC(DRV), .SAMPLE_CYC(SMP)) dut_i (
        .clk(clk), .por_i(por), .lvd_i(lvd), .wdog_i(wdog),
        .badop_i(badop), .badaddr_i(badaddr), .dbg_i(dbg), .pin_i(pin_w),
        .pin_drive_o(pin_drive), .sys_rst_o(sys_rst), .status_o(status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Call after setting inputs at a negedge; measures one whole sequence.
    task automatic run_seq(output int rise, output int drv, output int wt,
                           input int rel_at, input int extra_k);
        int k = 0;
        rise = 0; drv = 0; wt = 0;
        do begin
            @(negedge clk);
            rise++;
            wdog = 0; badop = 0; badaddr = 0; dbg = 0; lvd = 0;
        end while (!sys_rst && rise < 20);
        while (sys_rst && k < 500) begin
            k++;
            if (pin_drive) drv++; else wt++;
            if (k == rel_at) ext_low = 0;
            if (k == extra_k) badop = 1;
            if (k == extra_k + 1) badop = 0;
            @(negedge clk);
        end
    endtask

    function automatic int exp_bit(int c);
        case (c)
            0: return 8'h20;
            1: return 8'h10;
            2: return 8'h08;
            3: return 8'h00;
            default: return 8'h02;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int r, d, w;
        logic [7:0] snap;

        // R1: power-on with low voltage present
        lvd = 1;
        repeat (3) @(negedge clk);
        chk("R1 sys_rst under por", sys_rst, 1);
        chk("R1 drive under por", pin_drive, 1);
        chk("R1 status por+lvd", status, 8'h82);
        por = 0; lvd = 0;
        run_seq(r, d, w, 0, 0);
        chk("R2 drive after por", d, DRV);
        chk("R3 wait after por", w, SMP);
        chk("R1 status kept", status, 8'h82);

        // R1: power-on alone
        por = 1;
        repeat (2) @(negedge clk);
        chk("R1 status por only", status, 8'h80);
        por = 0;
        run_seq(r, d, w, 0, 0);
        chk("R2 drive por only", d, DRV);

        // R10: idle
        snap = status;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sys_rst || pin_drive) begin
                chk("R10 idle outputs", 1, 0);
                break;
            end
        end
        chk("R10 idle status", status, snap);

        // R4 R6 R8: sweep over single causes
        for (int c = 0; c < 5; c++) begin
            case (c)
                0: wdog = 1;
                1: badop = 1;
                2: badaddr = 1;
                3: dbg = 1;
                default: lvd = 1;
            endcase
            run_seq(r, d, w, 0, 0);
            chk($sformatf("R8 entry delay cause%0d", c), r, (c == 4) ? 3 : 1);
            chk($sformatf("R2 drive cause%0d", c), d, DRV);
            chk($sformatf("R3 wait cause%0d", c), w, SMP);
            chk($sformatf("R4 R6 status cause%0d", c), status, exp_bit(c));
        end

        // R5: second cause mid-sequence
        wdog = 1;
        run_seq(r, d, w, 0, 20);
        chk("R5 accumulated status", status, 8'h30);

        // R7 R8: pin held until just before sample
        ext_low = 1;
        run_seq(r, d, w, DRV + SMP - 1, 0);
        chk("R8 pin entry delay", r, 3);
        chk("R7 pin held status", status, 8'h40);
        chk("R3 wait pin", w, SMP);

        // R7 R4: pin released early
        ext_low = 1;
        run_seq(r, d, w, 50, 0);
        chk("R7 pin released status", status, 8'h00);
        repeat (5) @(negedge clk);
        chk("R7 no retrigger", sys_rst, 0);

        // R9: power-on over a running watchdog reset
        wdog = 1;
        @(negedge clk);
        wdog = 0;
        repeat (10) @(negedge clk);
        por = 1; wdog = 1;
        repeat (3) @(negedge clk);
        chk("R9 status por wins", status, 8'h80);
        por = 0; wdog = 0;
        run_seq(r, d, w, 0, 0);
        chk("R9 drive restart", d, DRV);
        chk("R9 wait restart", w, SMP);
        chk("R9 status final", status, 8'h80);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule